// File: doc/BRIEF.md
# IIR Noise Magnitude Estimator

This block gives a running estimate of how noisy the in-phase output of a QPSK matched filter is. It is meant for antenna pointing: the host reads the noise figure while the dish is moved. Each valid signed 8-bit sample is first reduced to a magnitude. A first leaky-integrator stage averages that magnitude. The distance between each magnitude and the current average is an instantaneous noise sample. A second leaky integrator averages those distances.

The noise figure goes up as noise power goes up and goes down as signal-to-noise ratio improves. It stays useful up to roughly 19 dB. Each stage has its own smoothing shift. Both stages clear on reset or on a single-cycle clear pulse. Converting the result to dB is left to software.

Top module: `noise_mag_est`

## Requirements
- R1: After reset, or in the cycle after `clr_i` is high, both accumulators are zero and both outputs read 0. `clr_i` takes priority over `smp_vld_i`.
- R2: The magnitude of a sample is its absolute value. The code -128 saturates to 127, so every magnitude lies in 0..127.
- R3: On each valid sample the average accumulator `A` (18 bits, 10 fraction bits) updates as `A += ((mag << 10) - A) >>> ka`. The shift is arithmetic and rounds toward minus infinity. `avg_mag_o` reads `A[17:10]`.
- R4: The deviation is `|mag - avg_mag_o|`. It uses the value `avg_mag_o` holds before the same sample updates it.
- R5: The noise accumulator `N` updates on the same valid sample by the R3 rule, with input `dev` and shift `kn`. `noise_mag_o` reads `N[17:10]`.
- R6: Shift inputs below 4 act as 4, and shift inputs above 10 act as 10.
- R7: While `smp_vld_i` and `clr_i` are both low, both outputs hold their values.
- R8: Outputs are registered. A sample that is valid at a rising edge shows its effect on the outputs right after that edge.
- R9: Neither output ever exceeds 127. An update never moves an accumulator past its target (`mag << 10` or `dev << 10`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous clear pulse for both accumulators |
| smp_vld_i | input | 1 | Sample valid strobe |
| smp_i | input | 8 | Signed in-phase sample |
| avg_shift_i | input | 4 | Smoothing shift for the average stage |
| nse_shift_i | input | 4 | Smoothing shift for the noise stage |
| avg_mag_o | output | 8 | Integer part of the average magnitude |
| noise_mag_o | output | 8 | Integer part of the averaged absolute deviation |

## Verification
A wrong fraction bit in either accumulator does not show at once. It changes the integer outputs only after a few samples, when the rounding-down steps pile up. For this reason the bench compares against an exact model on every sample over long runs. A fault in the deviation path or in the ordering of the two stages shows on `noise_mag_o` one cycle after the first valid sample that follows a change in amplitude. A missed shift clamp shows on the very first sample taken from zero.

// File: rtl/nme_pkg.sv
package nme_pkg;
    // Clamp a programmed shift into the supported window.
    function automatic logic [3:0] clamp_shift(input logic [3:0] k,
                                               input logic [3:0] kmin,
                                               input logic [3:0] kmax);
        logic [3:0] r;
        if (k < kmin)      r = kmin;
        else if (k > kmax) r = kmax;
        else               r = k;
        return r;
    endfunction
endpackage

// File: rtl/nme_abs.sv
module nme_abs #(
    parameter int W   = 8,
    parameter bit SAT = 1'b1
) (
    input  logic signed [W-1:0] x_i,
    output logic        [W-1:0] mag_o
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] neg_v;
    assign neg_v = -x_i;

    generate
        if (SAT) begin : g_sat
            always_comb begin
                if (x_i == MOST_NEG)  mag_o = MOST_POS;
                else if (x_i[W-1])    mag_o = neg_v;
                else                  mag_o = x_i;
            end
        end else begin : g_wrap
            always_comb mag_o = x_i[W-1] ? neg_v : x_i;
        end
    endgenerate

    always_comb begin
        AST_MAG_RANGE: assert (mag_o[W-1] == 1'b0 || !SAT); // R2
    end
endmodule

// File: rtl/nme_leaky.sv
module nme_leaky
    import nme_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int K_MIN = 4,
    parameter int K_MAX = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            vld_i,
    input  logic [IN_W-1:0] x_i,
    input  logic [3:0]      k_i,
    output logic [IN_W-1:0] int_o
);
    localparam int FRAC  = K_MAX;
    localparam int ACC_W = IN_W + FRAC;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } st_t;

    st_t st_d, st_q;
    logic [3:0]              k_eff;
    logic [ACC_W-1:0]        target;
    logic signed [ACC_W:0]   diff;
    logic signed [ACC_W:0]   step;
    logic signed [ACC_W:0]   sum;

    always_comb begin
        k_eff  = clamp_shift(k_i, 4'(K_MIN), 4'(K_MAX));
        target = {x_i, {FRAC{1'b0}}};
        diff   = $signed({1'b0, target}) - $signed({1'b0, st_q.acc});
        step   = diff >>> k_eff;
        sum    = $signed({1'b0, st_q.acc}) + step;
        st_d   = st_q;
        if (clr_i)      st_d.acc = '0;
        else if (vld_i) st_d.acc = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign int_o = st_q.acc[ACC_W-1:FRAC];

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_i && !clr_i) |=> $stable(st_q.acc)); // R7
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.acc == '0)); // R1
    AST_NO_OVERSHOOT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !clr_i && target >= st_q.acc) |=>
        (st_q.acc <= $past(target) && st_q.acc >= $past(st_q.acc))); // R9
    AST_NO_OVERSHOOT_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !clr_i && target < st_q.acc) |=>
        (st_q.acc >= $past(target) && st_q.acc < $past(st_q.acc))); // R3
    AST_SUM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |-> (sum[ACC_W] == 1'b0)); // R9
endmodule

// File: rtl/noise_mag_est.sv
module noise_mag_est #(
    parameter int IN_W  = 8,
    parameter int K_MIN = 4,
    parameter int K_MAX = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_i,
    input  logic                   smp_vld_i,
    input  logic signed [IN_W-1:0] smp_i,
    input  logic [3:0]             avg_shift_i,
    input  logic [3:0]             nse_shift_i,
    output logic [IN_W-1:0]        avg_mag_o,
    output logic [IN_W-1:0]        noise_mag_o
);
    logic [IN_W-1:0]        mag;
    logic [IN_W-1:0]        dev;
    logic signed [IN_W:0]   dlt;
    logic [IN_W:0]          dlt_abs;

    nme_abs #(.W(IN_W), .SAT(1'b1)) u_abs (
        .x_i   (smp_i),
        .mag_o (mag)
    );

    nme_leaky #(.IN_W(IN_W), .K_MIN(K_MIN), .K_MAX(K_MAX)) u_avg (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .vld_i (smp_vld_i),
        .x_i   (mag),
        .k_i   (avg_shift_i),
        .int_o (avg_mag_o)
    );

    // Deviation against the average held before this sample.
    always_comb begin
        dlt     = $signed({1'b0, mag}) - $signed({1'b0, avg_mag_o});
        dlt_abs = dlt[IN_W] ? 9'(-dlt) : dlt;
        dev     = dlt_abs[IN_W-1:0];
    end

    nme_leaky #(.IN_W(IN_W), .K_MIN(K_MIN), .K_MAX(K_MAX)) u_nse (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr_i),
        .vld_i (smp_vld_i),
        .x_i   (dev),
        .k_i   (nse_shift_i),
        .int_o (noise_mag_o)
    );

    AST_DEV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld_i |-> (dlt_abs[IN_W] == 1'b0 && !dev[IN_W-1])); // R4
    AST_AVG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        avg_mag_o[IN_W-1] == 1'b0); // R9
    AST_NSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        noise_mag_o[IN_W-1] == 1'b0); // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_vld_i && !clr_i) |=> ($stable(avg_mag_o) && $stable(noise_mag_o))); // R7
endmodule

// File: tb/sim_noise_mag_est.sv
module sim_noise_mag_est;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0, vld = 1'b0;
    logic signed [7:0] smp = '0;
    logic [3:0] ka = 4'd4, kn = 4'd4;
    logic [7:0] avg_o, nse_o;

    int n_chk = 0, n_fail = 0;
    int m_avg = 0, m_nse = 0;

    always #2.5 clk = ~clk;

    noise_mag_est u0 (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .smp_vld_i(vld), .smp_i(smp),
        .avg_shift_i(ka), .nse_shift_i(kn), .avg_mag_o(avg_o), .noise_mag_o(nse_o)
    );

    function automatic int kclamp(input int k);
        return (k < 4) ? 4 : ((k > 10) ? 10 : k);
    endfunction
    function automatic int mabs(input int v);
        if (v == -128) return 127;
        return (v < 0) ? -v : v;
    endfunction
    function automatic int leak(input int acc, input int x, input int k);
        int d;
        d = (x * 1024) - acc;
        return acc + (d >>> kclamp(k));
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, update the model, compare.
    task automatic step(input int s, input bit v, input bit c, input string tag);
        int mg, dv;
        smp = 8'(s); vld = v; clr = c;
        @(negedge clk);
        if (c) begin
            m_avg = 0; m_nse = 0;
        end else if (v) begin
            mg = mabs(s);
            dv = mg - (m_avg >>> 10);
            if (dv < 0) dv = -dv;
            m_avg = leak(m_avg, mg, int'(ka));
            m_nse = leak(m_nse, dv, int'(kn));
        end
        check({tag, " avg"}, int'(avg_o), m_avg >>> 10);
        check({tag, " nse"}, int'(nse_o), m_nse >>> 10);
        vld = 1'b0; clr = 1'b0;
    endtask

    typedef struct packed {
        logic [7:0] s;
        logic       v;
        logic [3:0] a;
        logic [3:0] n;
    } vec_t;
    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{8'd100, 1'b1, 4'd4, 4'd4}, '{8'd100, 1'b1, 4'd4, 4'd4},
        '{8'h9c,  1'b1, 4'd4, 4'd5}, '{8'd0,   1'b0, 4'd4, 4'd5},
        '{8'h80,  1'b1, 4'd5, 4'd4}, '{8'd127, 1'b1, 4'd6, 4'd6},
        '{8'd3,   1'b1, 4'd4, 4'd4}, '{8'hf0,  1'b1, 4'd4, 4'd7},
        '{8'd60,  1'b1, 4'd2, 4'd12},'{8'd60,  1'b0, 4'd9, 4'd9},
        '{8'hc4,  1'b1, 4'd8, 4'd4}, '{8'd0,   1'b1, 4'd4, 4'd4},
        '{8'd1,   1'b1, 4'd10,4'd10},'{8'h81,  1'b1, 4'd4, 4'd4},
        '{8'd90,  1'b1, 4'd15,4'd0}, '{8'd45,  1'b1, 4'd4, 4'd4}
    };

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset avg", int'(avg_o), 0);
        check("R1 reset nse", int'(nse_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 R5 R8: first sample 100 from zero at shift 4 -> 6400 -> 6
        ka = 4; kn = 4;
        step(100, 1, 0, "R3 first");
        check("R8 avg literal", int'(avg_o), 6);
        check("R5 nse literal", int'(nse_o), 6);
        step(0, 1, 1, "R1 clr");
        check("R1 clr beats vld", int'(avg_o), 0);

        // R2: -128 saturates -> 127*1024/16 = 8128 -> 7 (128 would give 8)
        step(-128, 1, 0, "R2 sat");
        check("R2 sat literal", int'(avg_o), 7);
        step(0, 0, 1, "R1 clr2");

        // R6: shift 0 behaves as 4
        ka = 0; kn = 0;
        step(100, 1, 0, "R6 low clamp");
        check("R6 low literal", int'(avg_o), 6);
        step(0, 0, 1, "R1 clr3");

        // Table walk covering R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            ka = VEC[i].a; kn = VEC[i].n;
            step(int'($signed(VEC[i].s)), VEC[i].v, 1'b0, $sformatf("R4 vec%0d", i));
        end

        // R7: idle cycles hold outputs
        for (int i = 0; i < 5; i++) step(77, 0, 0, "R7 idle");

        // R6 high clamp and R9 bound: long run of 127 at shift 15 acts as 10
        step(0, 0, 1, "R1 clr4");
        ka = 15; kn = 15;
        for (int i = 0; i < 3000; i++) step(127, 1, 0, "R6 high R9");
        check("R9 avg bound", int'(avg_o <= 8'd127), 1);

        // R4 R5: alternating amplitudes build noise
        ka = 5; kn = 4;
        for (int i = 0; i < 400; i++) step((i % 2) ? 20 : -110, 1, 0, "R5 alt");
        check("R5 noise nonzero", int'(nse_o > 8'd0), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule